// File: doc/BRIEF.md
# Banked Reorder Buffer with Packed Tag Allocation

This block tracks up to 72 in-flight operations for a three-lane dispatch front end. Storage is split into three banks of 24 entries, one bank per lane. All three banks share a single row pointer for allocation (the tail) and a single row pointer for retirement (the head), so the banks always move together. On every cycle that at least one lane dispatches, each dispatching lane takes the slot at the tail row of its own bank. The tail row then advances.

Every slot is named by an 8-bit tag that the block hands back on the dispatch port. Execution units later write a result into the slot once, by that tag. Retirement looks only at the head row. It walks the lanes in ascending order and sends finished results to the architectural register file. It stops at the first occupied slot that has not finished. The head advances once every occupied slot of the row has retired.

A slot can be marked as faulting, which covers both exceptions and mispredicted branches. Nothing happens to such a slot until it becomes the next one to retire. At that point the block discards every in-flight entry and raises a one-cycle flush. It then spends one recovery cycle with dispatch blocked.

The control is a four-state machine:
- **EMPTY**: no rows in flight. It moves to BUSY on an accepted dispatch.
- **BUSY**: some rows in flight.
  - It goes to FULL when the row count reaches 24.
  - It goes to EMPTY when the last row retires with no new dispatch.
  - It goes to RECOVER on a flush.
- **FULL**: every row is occupied and dispatch is refused. It returns to BUSY when a row retires, or goes to RECOVER on a flush.
- **RECOVER**: entered after a flush. It always returns to EMPTY on the next cycle.

Top module: `banked_rob`

## Requirements
- R1: The tag given to lane l is laid out as follows, and all lanes dispatching in one cycle share the same row and wrap values:
  - bits [1:0] hold l;
  - bits [6:2] hold the tail row, 0 to 23;
  - bit 7 holds the wrap bit.
- R2: The tail row advances by one after each cycle in which a dispatch is accepted. After row 23 it returns to row 0 and the wrap bit inverts. Cycles without an accepted dispatch leave the tags unchanged.
- R3: While 24 rows are in flight, disp_ready is low. A dispatch attempt in that state is ignored: no tag advance and no new entry.
- R4: A completion names a slot by its tag. The slot retires with the data given at completion and the destination given at dispatch. A slot is completed at most once.
- R5: Within the head row, retirement goes in lane order 0, 1, 2. It skips lanes that hold no entry and stops at the first occupied entry that is not complete. A later finished lane waits behind it.
- R6: The head row advances only after all of its occupied entries have retired. Entries in younger rows never retire before that, even if they are complete.
- R7: When the next entry to retire carries the fault flag:
  - flush is high for exactly one cycle, and flush_tag equals that entry's tag;
  - lanes before it in the same row retire in that same cycle;
  - the flagged entry and every younger entry produce no register-file write.
- R8: The cycle after a flush is a recovery cycle with disp_ready low. Dispatch then resumes at the same tail row and wrap value that were pending before the flush.
- R9: After reset, disp_ready is high, no retirement or flush is signalled, and the first tags carry row 0 and wrap 0.
- R10: Across the wrap of the row counter, retirement follows dispatch order. The head is older than the tail by this rule: compare rows when the wrap bits are equal, and reverse the comparison when they differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 3 | Per-lane dispatch request |
| disp_dest | input | 12 | Per-lane destination register, 4 bits per lane |
| disp_ready | output | 1 | Dispatch accepted this cycle if requested |
| disp_tag | output | 24 | Tag allocated to each lane at the current tail row |
| cmp_valid | input | 3 | Per-port completion strobe |
| cmp_tag | input | 24 | Tag of the completing slot, per port |
| cmp_data | input | 48 | Result data, 16 bits per port |
| cmp_flag | input | 3 | Completion carries an exception or mispredict |
| ret_valid | output | 3 | Per-lane register-file write this cycle |
| ret_tag | output | 24 | Tag of each retiring slot |
| ret_dest | output | 12 | Destination register of each retiring slot |
| ret_data | output | 48 | Result written to the register file |
| flush | output | 1 | Discard all in-flight entries |
| flush_tag | output | 8 | Tag of the faulting slot |

## Verification
Two situations are hardest to reach from the ports.

The first is the full state. Reaching it takes 24 rows of dispatch with every completion withheld. The bench then tries one more dispatch and checks that the tags and the scoreboard do not move. It then completes just the head row and watches dispatch reopen.

The second is a fault in the middle of a row, where an older lane must still retire in the flush cycle. To set this up, the faulting lane, the younger lane and a younger row are all completed first, and the older lane 0 is completed last. Retirement then meets both cases in a single cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_BUSY,
        ST_FULL,
        ST_RECOVER
    } rob_state_e;

    // Age rule: same wrap -> smaller row is older; differing wrap -> reversed.
    function automatic logic row_older(input logic a_wrap, input logic [7:0] a_row,
                                       input logic b_wrap, input logic [7:0] b_row);
        return (a_wrap == b_wrap) ? (a_row < b_row) : (a_row > b_row);
    endfunction

endpackage

// File: rtl/rob_bank.sv
module rob_bank #(
    parameter int ROWS      = 24,
    parameter int DATA_W    = 16,
    parameter int AREG_W    = 4,
    parameter int ROW_W     = 5,
    parameter int LANE_W    = 2,
    parameter int LANE_ID   = 0,
    parameter int CMP_PORTS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush_all,
    input  logic                          alloc_we,
    input  logic [ROW_W-1:0]              alloc_row,
    input  logic [AREG_W-1:0]             alloc_dest,
    input  logic [CMP_PORTS-1:0]          wr_valid,
    input  logic [CMP_PORTS*LANE_W-1:0]   wr_lane,
    input  logic [CMP_PORTS*ROW_W-1:0]    wr_row,
    input  logic [CMP_PORTS*DATA_W-1:0]   wr_data,
    input  logic [CMP_PORTS-1:0]          wr_flag,
    input  logic [ROW_W-1:0]              head_row,
    input  logic                          head_clr,
    output logic                          hd_occ,
    output logic                          hd_done,
    output logic                          hd_flag,
    output logic [AREG_W-1:0]             hd_dest,
    output logic [DATA_W-1:0]             hd_data
);

    logic [ROWS-1:0]   occ_q;
    logic [ROWS-1:0]   done_q;
    logic [ROWS-1:0]   flag_q;
    logic [AREG_W-1:0] dest_q [ROWS];
    logic [DATA_W-1:0] data_q [ROWS];

    logic [CMP_PORTS-1:0] hit;
    logic [ROW_W-1:0]     hit_row [CMP_PORTS];

    always_comb begin
        for (int p = 0; p < CMP_PORTS; p++) begin
            hit[p]     = wr_valid[p] && (wr_lane[p*LANE_W +: LANE_W] == LANE_W'(LANE_ID));
            hit_row[p] = wr_row[p*ROW_W +: ROW_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_all) begin
            occ_q  <= '0;
            done_q <= '0;
            flag_q <= '0;
        end else begin
            if (head_clr) begin
                occ_q[head_row] <= 1'b0;
            end
            if (alloc_we) begin
                occ_q[alloc_row]  <= 1'b1;
                done_q[alloc_row] <= 1'b0;
                flag_q[alloc_row] <= 1'b0;
                dest_q[alloc_row] <= alloc_dest;
            end
            for (int p = 0; p < CMP_PORTS; p++) begin
                if (hit[p]) begin
                    done_q[hit_row[p]] <= 1'b1;
                    flag_q[hit_row[p]] <= wr_flag[p];
                    data_q[hit_row[p]] <= wr_data[p*DATA_W +: DATA_W];
                end
            end
        end
    end

    assign hd_occ  = occ_q[head_row];
    assign hd_done = done_q[head_row];
    assign hd_flag = flag_q[head_row];
    assign hd_dest = dest_q[head_row];
    assign hd_data = data_q[head_row];

    // R4: a result lands only in a live slot that has not yet been written
    for (genvar p = 0; p < CMP_PORTS; p++) begin : g_once
        assert_write_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
            hit[p] |-> (occ_q[hit_row[p]] && !done_q[hit_row[p]]))
            else $error("completion into free or finished slot");
    end

endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
    parameter int LANES  = 3,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [LANES-1:0]  hd_occ,
    input  logic [LANES-1:0]  hd_done,
    input  logic [LANES-1:0]  hd_flag,
    output logic [LANES-1:0]  fire,
    output logic              row_done,
    output logic              fault,
    output logic [LANE_W-1:0] fault_lane
);

    logic blocked;

    always_comb begin
        fire       = '0;
        fault      = 1'b0;
        fault_lane = '0;
        blocked    = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (active && !blocked && hd_occ[l]) begin
                if (!hd_done[l]) begin
                    blocked = 1'b1;
                end else if (hd_flag[l]) begin
                    fault      = 1'b1;
                    fault_lane = LANE_W'(l);
                    blocked    = 1'b1;
                end else begin
                    fire[l] = 1'b1;
                end
            end
        end
        row_done = active && !blocked;
    end

    // R5: a lane never retires past an older occupied lane that stays behind
    for (genvar l = 1; l < LANES; l++) begin : g_order
        assert_lane_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
            fire[l] |-> (fire[l-1] || !hd_occ[l-1]))
            else $error("lane retired out of order");
    end

    // R7: a faulting row never counts as drained
    assert_fault_no_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !row_done)
        else $error("row drained during fault");

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int ROWS  = 24,
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_disp,
    input  logic             row_done,
    input  logic             flush,
    output logic             disp_ready,
    output logic             fire,
    output logic             active,
    output logic [ROW_W-1:0] tail_row,
    output logic             tail_wrap,
    output logic [ROW_W-1:0] head_row,
    output logic             head_wrap
);

    localparam int CNT_W = $clog2(ROWS + 1);

    rob_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // output process
    always_comb begin
        disp_ready = 1'b0;
        unique case (state_q)
            ST_EMPTY, ST_BUSY: disp_ready = !flush;
            ST_FULL, ST_RECOVER: disp_ready = 1'b0;
            default: disp_ready = 1'b0;
        endcase
        fire   = any_disp && disp_ready;
        active = (cnt_q != '0);
        cnt_d  = cnt_q + CNT_W'(fire) - CNT_W'(row_done);
    end

    // transition process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:   state_d = fire ? ST_BUSY : ST_EMPTY;
            ST_BUSY: begin
                if (flush)                       state_d = ST_RECOVER;
                else if (cnt_d == CNT_W'(ROWS))  state_d = ST_FULL;
                else if (cnt_d == '0)            state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (flush)                       state_d = ST_RECOVER;
                else if (cnt_d != CNT_W'(ROWS))  state_d = ST_BUSY;
            end
            ST_RECOVER: state_d = ST_EMPTY;
            default:    state_d = ST_EMPTY;
        endcase
    end

    // state register and row pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_EMPTY;
            cnt_q     <= '0;
            tail_row  <= '0;
            tail_wrap <= 1'b0;
            head_row  <= '0;
            head_wrap <= 1'b0;
        end else begin
            state_q <= state_d;
            if (flush) begin
                cnt_q     <= '0;
                head_row  <= tail_row;
                head_wrap <= tail_wrap;
            end else begin
                cnt_q <= cnt_d;
                if (fire) begin
                    if (tail_row == ROW_W'(ROWS - 1)) begin
                        tail_row  <= '0;
                        tail_wrap <= ~tail_wrap;
                    end else begin
                        tail_row <= tail_row + 1'b1;
                    end
                end
                if (row_done) begin
                    if (head_row == ROW_W'(ROWS - 1)) begin
                        head_row  <= '0;
                        head_wrap <= ~head_wrap;
                    end else begin
                        head_row <= head_row + 1'b1;
                    end
                end
            end
        end
    end

    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(ROWS)) |-> !disp_ready)
        else $error("dispatch open while full");

    assert_tail_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && tail_row == ROW_W'(ROWS - 1)) |=> (tail_row == '0 && tail_wrap != $past(tail_wrap)))
        else $error("tail did not wrap");

    assert_tail_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(tail_row) && $stable(tail_wrap)))
        else $error("tail moved without dispatch");

    assert_flush_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush)
        else $error("flush longer than one cycle");

    assert_recover_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !disp_ready)
        else $error("dispatch open in recovery");

    assert_head_older_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && cnt_q != CNT_W'(ROWS)) |->
            row_older(head_wrap, 8'(head_row), tail_wrap, 8'(tail_row)))
        else $error("head not older than tail");

endmodule

// File: rtl/banked_rob.sv
module banked_rob #(
    parameter int LANES     = 3,
    parameter int ROWS      = 24,
    parameter int DATA_W    = 16,
    parameter int AREG_W    = 4,
    parameter int CMP_PORTS = 3,
    localparam int LANE_W   = $clog2(LANES),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int TAG_W    = 1 + ROW_W + LANE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            disp_valid,
    input  logic [LANES*AREG_W-1:0]     disp_dest,
    output logic                        disp_ready,
    output logic [LANES*TAG_W-1:0]      disp_tag,
    input  logic [CMP_PORTS-1:0]        cmp_valid,
    input  logic [CMP_PORTS*TAG_W-1:0]  cmp_tag,
    input  logic [CMP_PORTS*DATA_W-1:0] cmp_data,
    input  logic [CMP_PORTS-1:0]        cmp_flag,
    output logic [LANES-1:0]            ret_valid,
    output logic [LANES*TAG_W-1:0]      ret_tag,
    output logic [LANES*AREG_W-1:0]     ret_dest,
    output logic [LANES*DATA_W-1:0]     ret_data,
    output logic                        flush,
    output logic [TAG_W-1:0]            flush_tag
);

    logic             fire, active, row_done;
    logic [ROW_W-1:0] tail_row, head_row;
    logic             tail_wrap, head_wrap;
    logic [LANE_W-1:0] fault_lane;
    logic [LANES-1:0] hd_occ, hd_done, hd_flag;

    logic [CMP_PORTS*LANE_W-1:0] c_lane;
    logic [CMP_PORTS*ROW_W-1:0]  c_row;
    logic [CMP_PORTS-1:0]        c_wrap;

    always_comb begin
        for (int p = 0; p < CMP_PORTS; p++) begin
            c_lane[p*LANE_W +: LANE_W] = cmp_tag[p*TAG_W +: LANE_W];
            c_row[p*ROW_W +: ROW_W]    = cmp_tag[p*TAG_W + LANE_W +: ROW_W];
            c_wrap[p]                  = cmp_tag[p*TAG_W + TAG_W - 1];
        end
    end

    rob_ctrl #(.ROWS(ROWS), .ROW_W(ROW_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .any_disp(|disp_valid), .row_done(row_done),
        .flush(flush), .disp_ready(disp_ready), .fire(fire), .active(active),
        .tail_row(tail_row), .tail_wrap(tail_wrap),
        .head_row(head_row), .head_wrap(head_wrap)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rob_bank #(
            .ROWS(ROWS), .DATA_W(DATA_W), .AREG_W(AREG_W), .ROW_W(ROW_W),
            .LANE_W(LANE_W), .LANE_ID(l), .CMP_PORTS(CMP_PORTS)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .flush_all(flush),
            .alloc_we(fire && disp_valid[l]), .alloc_row(tail_row),
            .alloc_dest(disp_dest[l*AREG_W +: AREG_W]),
            .wr_valid(cmp_valid), .wr_lane(c_lane), .wr_row(c_row),
            .wr_data(cmp_data), .wr_flag(cmp_flag),
            .head_row(head_row), .head_clr(ret_valid[l]),
            .hd_occ(hd_occ[l]), .hd_done(hd_done[l]), .hd_flag(hd_flag[l]),
            .hd_dest(ret_dest[l*AREG_W +: AREG_W]),
            .hd_data(ret_data[l*DATA_W +: DATA_W])
        );
        // R1: packed tag = {wrap, row, lane}
        assign disp_tag[l*TAG_W +: TAG_W] = {tail_wrap, tail_row, LANE_W'(l)};
        assign ret_tag[l*TAG_W +: TAG_W]  = {head_wrap, head_row, LANE_W'(l)};
    end

    rob_retire #(.LANES(LANES), .LANE_W(LANE_W)) u_retire (
        .clk(clk), .rst_n(rst_n), .active(active),
        .hd_occ(hd_occ), .hd_done(hd_done), .hd_flag(hd_flag),
        .fire(ret_valid), .row_done(row_done),
        .fault(flush), .fault_lane(fault_lane)
    );

    assign flush_tag = {head_wrap, head_row, fault_lane};

    // R4: a completing tag carries the wrap value of a live row
    for (genvar p = 0; p < CMP_PORTS; p++) begin : g_cmp_chk
        assert_cmp_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_valid[p] |-> (c_wrap[p] == head_wrap || c_wrap[p] == tail_wrap))
            else $error("completion tag from a dead epoch");
    end

endmodule

// File: tb/banked_rob_bench.sv
module banked_rob_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  disp_valid = '0;
    logic [11:0] disp_dest = '0;
    logic        disp_ready;
    logic [23:0] disp_tag;
    logic [2:0]  cmp_valid = '0;
    logic [23:0] cmp_tag = '0;
    logic [47:0] cmp_data = '0;
    logic [2:0]  cmp_flag = '0;
    logic [2:0]  ret_valid;
    logic [23:0] ret_tag;
    logic [11:0] ret_dest;
    logic [47:0] ret_data;
    logic        flush;
    logic [7:0]  flush_tag;

    always #10 clk = ~clk;

    banked_rob u_banked_rob (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_dest(disp_dest),
        .disp_ready(disp_ready), .disp_tag(disp_tag), .cmp_valid(cmp_valid),
        .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_flag(cmp_flag),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_dest(ret_dest),
        .ret_data(ret_data), .flush(flush), .flush_tag(flush_tag)
    );

    typedef struct packed {
        logic [7:0] tag;
        logic [3:0] dest;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] val_of [256];
    int          checks = 0;
    int          fails = 0;
    int          n_ret = 0;
    int          n_flush = 0;
    bit          fin = 1'b0;
    logic [7:0]  cur_tag [3];
    logic [4:0]  exp_row = '0;
    logic        exp_wrap = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [7:0] t, input int salt);
        return {t ^ 8'(salt), t + 8'(salt * 3)};
    endfunction

    // driver: dispatch; pushes expected retirements on acceptance
    task automatic do_dispatch(input logic [2:0] mask, input logic [3:0] d0,
                               input logic [3:0] d1, input logic [3:0] d2);
        disp_valid = mask;
        disp_dest  = {d2, d1, d0};
        #1;
        for (int l = 0; l < 3; l++) cur_tag[l] = disp_tag[l*8 +: 8];
        if (disp_ready) begin
            for (int l = 0; l < 3; l++)
                if (mask[l]) sb_q.push_back('{tag: cur_tag[l], dest: disp_dest[l*4 +: 4]});
            if (exp_row == 5'd23) begin exp_row = '0; exp_wrap = ~exp_wrap; end
            else exp_row = exp_row + 1'b1;
        end
        @(posedge clk); #2;
        disp_valid = '0;
    endtask

    task automatic do_complete(input logic [2:0] mask, input logic [7:0] t0, input logic [7:0] t1,
                               input logic [7:0] t2, input logic [2:0] flg, input int salt);
        logic [7:0] tt [3];
        tt[0] = t0; tt[1] = t1; tt[2] = t2;
        for (int p = 0; p < 3; p++) begin
            cmp_tag[p*8 +: 8]   = tt[p];
            cmp_data[p*16 +: 16] = mk(tt[p], salt);
            if (mask[p]) val_of[tt[p]] = mk(tt[p], salt);
        end
        cmp_valid = mask;
        cmp_flag  = flg;
        @(posedge clk); #2;
        cmp_valid = '0;
        cmp_flag  = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // monitor: pops expected items as retirements appear
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            for (int l = 0; l < 3; l++) begin
                if (ret_valid[l]) begin
                    n_ret++;
                    if (sb_q.size() == 0) begin
                        chk(1'b0, "R10 unexpected retire", ret_tag[l*8 +: 8], 0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        chk(ret_tag[l*8 +: 8] == e.tag, "R10 retire order",
                            ret_tag[l*8 +: 8], e.tag);
                        chk(ret_dest[l*4 +: 4] == e.dest, "R4 dest", ret_dest[l*4 +: 4], e.dest);
                        chk(ret_data[l*16 +: 16] == val_of[e.tag], "R4 data",
                            ret_data[l*16 +: 16], val_of[e.tag]);
                    end
                end
            end
            if (flush) begin
                n_flush++;
                chk(sb_q.size() != 0 && flush_tag == sb_q[0].tag, "R7 flush tag",
                    flush_tag, (sb_q.size() != 0) ? sb_q[0].tag : 0);
                sb_q.delete();
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] ft [24][2];
        logic [7:0] x [3];
        logic [7:0] y0, saved, t_before;
        int r0;

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R9 reset state
        chk(disp_ready == 1'b1, "R9 ready", disp_ready, 1);
        chk(ret_valid == 3'b000 && flush == 1'b0, "R9 quiet", {flush, ret_valid}, 0);
        chk(disp_tag == {8'h02, 8'h01, 8'h00}, "R9 first tags", disp_tag, 24'h020100);
        #1;

        // R1 tag layout
        do_dispatch(3'b111, 4'd1, 4'd2, 4'd3);
        chk(cur_tag[0] == 8'h00 && cur_tag[1] == 8'h01 && cur_tag[2] == 8'h02,
            "R1 row0 tags", {cur_tag[2], cur_tag[1], cur_tag[0]}, 24'h020100);
        do_dispatch(3'b101, 4'd4, 4'd0, 4'd6);
        chk(cur_tag[0] == 8'h04 && cur_tag[2] == 8'h06, "R1 row1 tags",
            {cur_tag[2], cur_tag[0]}, 16'h0604);
        idle(2);
        // R2 idle cycles leave the tail alone
        chk(disp_tag[7:0] == 8'h08, "R2 hold", disp_tag[7:0], 8'h08);

        // R6 younger row complete first: nothing retires
        do_complete(3'b101, 8'h04, 8'h00, 8'h06, 3'b000, 1);
        idle(2);
        chk(n_ret == 0, "R6 younger waits", n_ret, 0);
        // R5 lane0 missing blocks lanes 1 and 2
        do_complete(3'b110, 8'h00, 8'h01, 8'h02, 3'b000, 2);
        idle(2);
        chk(n_ret == 0, "R5 blocked by lane0", n_ret, 0);
        do_complete(3'b001, 8'h00, 8'h00, 8'h00, 3'b000, 3);
        idle(3);
        chk(n_ret == 5, "R6 both rows drained", n_ret, 5);

        // R5 partial row: lane2 done, lane1 pending
        do_dispatch(3'b111, 4'd7, 4'd8, 4'd9);
        do_complete(3'b101, 8'h08, 8'h00, 8'h0A, 3'b000, 4);
        idle(2);
        chk(n_ret == 6, "R5 lane2 waits for lane1", n_ret, 6);
        do_complete(3'b010, 8'h00, 8'h09, 8'h00, 3'b000, 5);
        idle(2);
        chk(n_ret == 8, "R5 row finishes", n_ret, 8);

        // R2 / R10 wrap across row 23
        for (int i = 0; i < 26; i++) begin
            logic [7:0] et;
            et = {exp_wrap, exp_row, 2'b00};
            do_dispatch(3'b111, 4'(i), 4'(i + 1), 4'(i + 2));
            chk(cur_tag[0] == et && cur_tag[1] == (et | 8'h01) && cur_tag[2] == (et | 8'h02),
                "R2 tag sequence", cur_tag[0], et);
            do_complete(3'b111, cur_tag[0], cur_tag[1], cur_tag[2], 3'b000, 6 + i);
        end
        chk(exp_wrap == 1'b1, "R2 wrap reached", exp_wrap, 1);
        idle(4);
        chk(sb_q.size() == 0, "R10 all retired in order", sb_q.size(), 0);

        // R3 fill all 24 rows
        for (int i = 0; i < 24; i++) begin
            do_dispatch(3'b011, 4'(i), 4'(15 - i), 4'd0);
            ft[i][0] = cur_tag[0];
            ft[i][1] = cur_tag[1];
        end
        #1;
        chk(disp_ready == 1'b0, "R3 full blocks", disp_ready, 0);
        t_before = disp_tag[7:0];
        #1;
        do_dispatch(3'b111, 4'd1, 4'd1, 4'd1);
        chk(disp_tag[7:0] == t_before && sb_q.size() == 48, "R3 ignored dispatch",
            disp_tag[7:0], t_before);
        do_complete(3'b011, ft[0][0], ft[0][1], 8'h00, 3'b000, 40);
        idle(1);
        chk(disp_ready == 1'b1, "R3 reopen after row retires", disp_ready, 1);
        for (int i = 1; i < 24; i++)
            do_complete(3'b011, ft[i][0], ft[i][1], 8'h00, 3'b000, 41 + i);
        idle(4);
        chk(sb_q.size() == 0, "R6 full drain", sb_q.size(), 0);

        // R7 / R8 fault in mid-row lane
        do_dispatch(3'b111, 4'd10, 4'd11, 4'd12);
        for (int l = 0; l < 3; l++) x[l] = cur_tag[l];
        do_dispatch(3'b001, 4'd13, 4'd0, 4'd0);
        y0 = cur_tag[0];
        saved = disp_tag[7:0];
        do_complete(3'b001, y0, 8'h00, 8'h00, 3'b000, 70);
        do_complete(3'b110, 8'h00, x[1], x[2], 3'b010, 71);
        idle(1);
        chk(flush == 1'b0, "R5 fault waits for lane0", flush, 0);
        r0 = n_ret;
        do_complete(3'b001, x[0], 8'h00, 8'h00, 3'b000, 72);
        chk(flush == 1'b1 && ret_valid == 3'b001, "R7 flush with older lane",
            {flush, ret_valid}, 4'b1001);
        chk(flush_tag == x[1], "R7 flush tag port", flush_tag, x[1]);
        idle(1);
        chk(flush == 1'b0 && disp_ready == 1'b0 && ret_valid == 3'b000, "R8 recovery cycle",
            {flush, disp_ready, ret_valid}, 0);
        idle(1);
        chk(disp_ready == 1'b1 && disp_tag[7:0] == saved, "R8 resume tag", disp_tag[7:0], saved);
        idle(2);
        chk(n_ret == r0 + 1 && n_flush == 1, "R7 no younger writes", n_ret, r0 + 1);
        do_dispatch(3'b111, 4'd1, 4'd2, 4'd3);
        do_complete(3'b111, cur_tag[0], cur_tag[1], cur_tag[2], 3'b000, 80);
        idle(3);
        chk(n_ret == r0 + 4 && sb_q.size() == 0, "R8 normal after recovery", n_ret, r0 + 4);

        if (!fin) begin
            fin = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule